// File: doc/BRIEF.md
# MEI Snoop Response Controller

This block sits beside a small data cache and decides how the cache reacts to address-only transactions that other masters place on the shared bus. The cache keeps each line in one of three coherence states: modified, exclusive or invalid. For every snooped transaction the block looks up a direct-mapped tag and state store of 16 lines. From the 5-bit transaction type code, the burst flag and the caching-inhibited flag, it decides three things: whether to ask the bus for an address retry, whether to request a push of a dirty line, and which state the line moves to.

A single load-reservation register is held next to the store. Certain write transactions clear it when they name the reserved 32-byte block. The local side of the cache fills lines through a fill port and sets the reservation through a set port. The data array, the push data transfer and bus arbitration live outside the block.

Top module: `mei_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, no reservation is held, and retry_o, push_o and upd_valid_o are low.
- R2: retry_o, push_o, push_idx_o, upd_valid_o and upd_state_o are registered one clock after a cycle with snp_valid high, and each lasts one cycle. With snp_valid low they stay low in the next cycle. upd_state_o reports the state of the snooped line after the snoop, encoded I=00, E=01 and M=10, and reports 00 on a miss. push_idx_o is the line index, which is address bits [8:5]. push_o is never high without retry_o.
- R3: A snoop hits when the stored tag equals address bits [31:9] at index bits [8:5] and the stored state is not I.
- R4: Codes 11000, 11100, 00001, 01001 and 01101, the reserved codes 00101 and 1xx01, and every other code not named in R5 to R8 change no state and raise neither retry nor push.
- R5: Code 00010, write-with-flush, moves an E hit to I. On an M hit it raises retry and push and leaves the line I. A miss does nothing.
- R6: Code 00110, write-with-kill, moves any hit line to I, including an M line, and raises neither retry nor push.
- R7: Code 01010 with snp_burst=0 and snp_inhibit=1 leaves an E hit in E. On an M hit it raises retry and push and leaves the line E.
- R8: Code 01010 in any other form moves an E hit to I. On an M hit it raises retry and push and leaves the line I. A miss on either read form does nothing.
- R9: Codes 00010 and 00110 clear the reservation when its block address (bits [31:5]) equals that of the snoop address, whether the cache hits or misses. No other code touches the reservation.
- R10: When fill_valid is high, the line at index fill_addr[8:5] takes tag fill_addr[31:9] and state fill_state from the next clock.
- R11: rsv_set records the block of rsv_addr as reserved, and rsv_valid_o goes high from the next clock. If a clearing snoop names the same block in the same cycle, the clear wins and rsv_valid_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snooped transaction present this cycle |
| snp_type | input | 5 | Transaction type code |
| snp_addr | input | 32 | Snooped address |
| snp_burst | input | 1 | 1 = burst, 0 = single beat |
| snp_inhibit | input | 1 | Caching-inhibited attribute |
| fill_valid | input | 1 | Local line fill strobe |
| fill_addr | input | 32 | Address of the filled line |
| fill_state | input | 2 | State given to the filled line |
| rsv_set | input | 1 | Local reservation set strobe |
| rsv_addr | input | 32 | Address of the new reservation |
| retry_o | output | 1 | Address retry pulse |
| push_o | output | 1 | Request to push a modified line |
| push_idx_o | output | 4 | Index of the line to push |
| upd_valid_o | output | 1 | Snoop result valid |
| upd_state_o | output | 2 | Line state after the snoop |
| rsv_valid_o | output | 1 | Reservation held |

## Verification
On every cycle the assertions check the pulse discipline: no result without a strobe, push only together with retry, and a pushed line never left modified. They also check that the no-action codes and write-with-kill stay quiet on retry, and that fills and reservation clears land in the following cycle. The state each transaction type leaves behind depends on what was filled earlier and on the beat form, so only the bench's reference model can show it, by comparing upd_state_o and rsv_valid_o with expected values over long random runs and a few directed collisions.

// File: rtl/mei_snoop_pkg.sv
package mei_snoop_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_E = 2'b01,
        ST_M = 2'b10
    } line_st_e;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_FLUSH   = 3'd1,
        ACT_KILL    = 3'd2,
        ACT_RD_KEEP = 3'd3,
        ACT_RD_DROP = 3'd4
    } snp_act_e;

    localparam logic [4:0] CODE_WR_FLUSH = 5'b00010;
    localparam logic [4:0] CODE_WR_KILL  = 5'b00110;
    localparam logic [4:0] CODE_READ     = 5'b01010;

endpackage

// File: rtl/mei_snoop_decode.sv
module mei_snoop_decode
    import mei_snoop_pkg::*;
(
    input  logic [4:0] type_i,
    input  logic       burst_i,
    input  logic       inhibit_i,
    output snp_act_e   act_o,
    output logic       cancel_o
);

    always_comb begin
        act_o    = ACT_NONE;
        cancel_o = 1'b0;
        unique case (type_i)
            CODE_WR_FLUSH: begin
                act_o    = ACT_FLUSH;
                cancel_o = 1'b1;
            end
            CODE_WR_KILL: begin
                act_o    = ACT_KILL;
                cancel_o = 1'b1;
            end
            CODE_READ: begin
                // single-beat inhibited read keeps the copy, all else drops it
                act_o = (!burst_i && inhibit_i) ? ACT_RD_KEEP : ACT_RD_DROP;
            end
            default: begin
                act_o    = ACT_NONE;
                cancel_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mei_line_store.sv
module mei_line_store
    import mei_snoop_pkg::*;
#(
    parameter int LINES = 16,
    parameter int TAG_W = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic [TAG_W-1:0]         rd_tag,
    output line_st_e                 rd_state,
    input  logic                     upd_en,
    input  logic [$clog2(LINES)-1:0] upd_idx,
    input  line_st_e                 upd_state,
    input  logic                     fill_en,
    input  logic [$clog2(LINES)-1:0] fill_idx,
    input  logic [TAG_W-1:0]         fill_tag,
    input  line_st_e                 fill_state
);

    typedef struct packed {
        logic     [LINES-1:0][TAG_W-1:0] tag;
        line_st_e [LINES-1:0]            st;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (fill_en) begin
            store_d.tag[fill_idx] = fill_tag;
            store_d.st[fill_idx]  = fill_state;
        end
        // a snoop update is written last and wins on a shared index
        if (upd_en) begin
            store_d.st[upd_idx] = upd_state;
        end
    end

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store_q.tag[g] <= '0;
                    store_q.st[g]  <= ST_I;
                end else begin
                    store_q.tag[g] <= store_d.tag[g];
                    store_q.st[g]  <= store_d.st[g];
                end
            end
        end
    endgenerate

    assign rd_tag   = store_q.tag[rd_idx];
    assign rd_state = store_q.st[rd_idx];

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en && !(upd_en && upd_idx == fill_idx)
        |=> store_q.st[$past(fill_idx)] == $past(fill_state)
            && store_q.tag[$past(fill_idx)] == $past(fill_tag)); // R10

    AST_UPD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> store_q.st[$past(upd_idx)] == $past(upd_state)); // R2

endmodule

// File: rtl/mei_rsv_reg.sv
module mei_rsv_reg #(
    parameter int BLK_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [BLK_W-1:0] set_blk,
    input  logic             cancel_en,
    input  logic [BLK_W-1:0] cancel_blk,
    output logic             valid_o
);

    typedef struct packed {
        logic             valid;
        logic [BLK_W-1:0] blk;
    } rsv_t;

    rsv_t rsv_d, rsv_q;

    always_comb begin
        rsv_d = rsv_q;
        if (set_en) begin
            rsv_d.blk   = set_blk;
            rsv_d.valid = !(cancel_en && cancel_blk == set_blk);
        end else if (cancel_en && rsv_q.valid && cancel_blk == rsv_q.blk) begin
            rsv_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsv_q <= '0;
        end else begin
            rsv_q <= rsv_d;
        end
    end

    assign valid_o = rsv_q.valid;

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_en && !(cancel_en && cancel_blk == set_blk) |=> valid_o); // R11

    AST_CANCEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en && cancel_en && cancel_blk == set_blk |=> !valid_o); // R11

    AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !set_en && cancel_en && valid_o && cancel_blk == rsv_q.blk |=> !valid_o); // R9

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !set_en && !cancel_en |=> $stable(valid_o)); // R9

endmodule

// File: rtl/mei_snoop_ctrl.sv
module mei_snoop_ctrl
    import mei_snoop_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LINES     = 16,
    parameter int BLK_BYTES = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     snp_valid,
    input  logic [4:0]               snp_type,
    input  logic [ADDR_W-1:0]        snp_addr,
    input  logic                     snp_burst,
    input  logic                     snp_inhibit,
    input  logic                     fill_valid,
    input  logic [ADDR_W-1:0]        fill_addr,
    input  logic [1:0]               fill_state,
    input  logic                     rsv_set,
    input  logic [ADDR_W-1:0]        rsv_addr,
    output logic                     retry_o,
    output logic                     push_o,
    output logic [$clog2(LINES)-1:0] push_idx_o,
    output logic                     upd_valid_o,
    output logic [1:0]               upd_state_o,
    output logic                     rsv_valid_o
);

    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int BLK_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic             retry;
        logic             push;
        logic [IDX_W-1:0] idx;
        logic             upd_valid;
        line_st_e         upd_state;
    } resp_t;

    snp_act_e         act;
    logic             cancel;
    logic [TAG_W-1:0] rd_tag;
    line_st_e         rd_state;
    logic [IDX_W-1:0] snp_idx;
    logic [TAG_W-1:0] snp_tag;
    logic             hit;
    logic             wr_en;
    line_st_e         wr_state;
    resp_t            resp_d, resp_q;

    assign snp_idx = snp_addr[OFF_W +: IDX_W];
    assign snp_tag = snp_addr[ADDR_W-1 -: TAG_W];

    mei_snoop_decode u_decode (
        .type_i    (snp_type),
        .burst_i   (snp_burst),
        .inhibit_i (snp_inhibit),
        .act_o     (act),
        .cancel_o  (cancel)
    );

    mei_line_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (snp_idx),
        .rd_tag     (rd_tag),
        .rd_state   (rd_state),
        .upd_en     (wr_en),
        .upd_idx    (snp_idx),
        .upd_state  (wr_state),
        .fill_en    (fill_valid),
        .fill_idx   (fill_addr[OFF_W +: IDX_W]),
        .fill_tag   (fill_addr[ADDR_W-1 -: TAG_W]),
        .fill_state (line_st_e'(fill_state))
    );

    mei_rsv_reg #(
        .BLK_W (BLK_W)
    ) u_rsv (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (rsv_set),
        .set_blk    (rsv_addr[ADDR_W-1:OFF_W]),
        .cancel_en  (snp_valid && cancel),
        .cancel_blk (snp_addr[ADDR_W-1:OFF_W]),
        .valid_o    (rsv_valid_o)
    );

    assign hit = (rd_state != ST_I) && (rd_tag == snp_tag);

    always_comb begin
        resp_d   = '0;
        wr_en    = 1'b0;
        wr_state = rd_state;
        if (snp_valid) begin
            resp_d.upd_valid = 1'b1;
            resp_d.idx       = snp_idx;
            if (hit) begin
                wr_en = 1'b1;
                unique case (act)
                    ACT_FLUSH, ACT_RD_DROP: begin
                        wr_state     = ST_I;
                        resp_d.retry = (rd_state == ST_M);
                        resp_d.push  = (rd_state == ST_M);
                    end
                    ACT_KILL: begin
                        wr_state = ST_I;
                    end
                    ACT_RD_KEEP: begin
                        wr_state     = ST_E;
                        resp_d.retry = (rd_state == ST_M);
                        resp_d.push  = (rd_state == ST_M);
                    end
                    default: begin
                        wr_state = rd_state;
                    end
                endcase
                resp_d.upd_state = wr_state;
            end else begin
                resp_d.upd_state = ST_I;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign retry_o     = resp_q.retry;
    assign push_o      = resp_q.push;
    assign push_idx_o  = resp_q.idx;
    assign upd_valid_o = resp_q.upd_valid;
    assign upd_state_o = resp_q.upd_state;

    AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> !retry_o && !push_o && !upd_valid_o); // R2

    AST_PUSH_WITH_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> retry_o); // R2

    AST_PUSH_NOT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> upd_state_o != ST_M); // R7

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && act == ACT_NONE |=> !retry_o && !push_o); // R4

    AST_KILL_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && act == ACT_KILL |=> !retry_o && upd_state_o == ST_I); // R6

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && !hit |=> !retry_o && upd_state_o == ST_I); // R3

endmodule

// File: tb/mei_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module mei_snoop_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snp_valid = 1'b0;
    logic [4:0]  snp_type = '0;
    logic [31:0] snp_addr = '0;
    logic        snp_burst = 1'b0;
    logic        snp_inhibit = 1'b0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [1:0]  fill_state = '0;
    logic        rsv_set = 1'b0;
    logic [31:0] rsv_addr = '0;
    logic        retry_o, push_o, upd_valid_o, rsv_valid_o;
    logic [3:0]  push_idx_o;
    logic [1:0]  upd_state_o;

    always #2.5 clk = ~clk;

    mei_snoop_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_type(snp_type),
        .snp_addr(snp_addr), .snp_burst(snp_burst), .snp_inhibit(snp_inhibit),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_state(fill_state),
        .rsv_set(rsv_set), .rsv_addr(rsv_addr), .retry_o(retry_o), .push_o(push_o),
        .push_idx_o(push_idx_o), .upd_valid_o(upd_valid_o), .upd_state_o(upd_state_o),
        .rsv_valid_o(rsv_valid_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model
    logic [22:0] m_tag [16];
    logic [1:0]  m_st  [16];
    logic        m_rv;
    logic [26:0] m_rblk;

    task automatic chk(input string tag, input string what, input logic [31:0] act_v, input logic [31:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act_v, exp_v);
        end
    endtask

    // 0 none, 1 flush, 2 kill, 3 keep-read, 4 drop-read
    function automatic int kind(input logic [4:0] t, input logic b, input logic inh);
        if (t == 5'b00010) return 1;
        if (t == 5'b00110) return 2;
        if (t == 5'b01010) return (!b && inh) ? 3 : 4;
        return 0;
    endfunction

    function automatic string kind_tag(input int k);
        case (k)
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            default: return "R4";
        endcase
    endfunction

    // called at a negedge with inputs already driven; checks after the next edge
    task automatic step(input string tag_over);
        int          k = kind(snp_type, snp_burst, snp_inhibit);
        logic [3:0]  ix = snp_addr[8:5];
        logic        hit = (m_st[ix] != 2'b00) && (m_tag[ix] == snp_addr[31:9]);
        logic [1:0]  ns = m_st[ix];
        logic        er = 1'b0;
        logic        canc;
        string       tg;
        if (hit) begin
            case (k)
                1, 4: begin er = (m_st[ix] == 2'b10); ns = 2'b00; end
                2: ns = 2'b00;
                3: begin er = (m_st[ix] == 2'b10); ns = 2'b01; end
                default: ns = m_st[ix];
            endcase
        end
        canc = snp_valid && (k == 1 || k == 2);
        tg = (tag_over.len() != 0) ? tag_over : kind_tag(k);
        @(posedge clk);
        @(negedge clk);
        chk("R2", "upd_valid", upd_valid_o, snp_valid);
        chk(snp_valid ? tg : "R2", "retry", retry_o, snp_valid && er);
        chk(snp_valid ? tg : "R2", "push", push_o, snp_valid && er);
        if (snp_valid) begin
            chk(tg, "upd_state", upd_state_o, hit ? ns : 2'b00);
            if (er) chk("R2", "push_idx", push_idx_o, ix);
        end
        // update model
        if (fill_valid && !(snp_valid && hit && fill_addr[8:5] == ix)) begin
            m_tag[fill_addr[8:5]] = fill_addr[31:9];
            m_st[fill_addr[8:5]]  = fill_state;
        end
        if (snp_valid && hit) m_st[ix] = ns;
        if (rsv_set) begin
            m_rblk = rsv_addr[31:5];
            m_rv   = !(canc && snp_addr[31:5] == rsv_addr[31:5]);
        end else if (canc && m_rv && snp_addr[31:5] == m_rblk) begin
            m_rv = 1'b0;
        end
        chk(rsv_set ? "R11" : "R9", "rsv_valid", rsv_valid_o, m_rv);
    endtask

    task automatic idle();
        snp_valid = 0; fill_valid = 0; rsv_set = 0;
    endtask

    task automatic fill(input logic [31:0] a, input logic [1:0] s);
        idle();
        fill_valid = 1; fill_addr = a; fill_state = s;
        step("R10");
        idle();
    endtask

    task automatic snoop(input logic [31:0] a, input logic [4:0] t, input logic b, input logic inh, input string tg);
        idle();
        snp_valid = 1; snp_addr = a; snp_type = t; snp_burst = b; snp_inhibit = inh;
        step(tg);
        idle();
    endtask

    localparam logic [31:0] A0 = 32'h1234_5060;
    localparam logic [31:0] A1 = 32'hABCD_0060; // same index as A0, other tag

    logic [22:0] pool [4];

    initial begin
        for (int i = 0; i < 16; i++) begin m_tag[i] = '0; m_st[i] = 2'b00; end
        m_rv = 0; m_rblk = '0;
        pool[0] = 23'h000001; pool[1] = 23'h2ABCDE; pool[2] = 23'h7FFFFF; pool[3] = 23'h000000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "retry", retry_o, 0);
        chk("R1", "push", push_o, 0);
        chk("R1", "upd_valid", upd_valid_o, 0);
        chk("R1", "rsv_valid", rsv_valid_o, 0);
        snoop(32'h0, 5'b01010, 1, 0, "R1");          // all lines invalid: miss

        fill(A0, 2'b01);
        snoop(A0, 5'b01010, 0, 1, "R7");             // E stays E
        snoop(A1, 5'b01010, 1, 0, "R3");             // tag mismatch: miss
        snoop(A0 | 32'h1F, 5'b11000, 0, 0, "R4");    // no-op code, offset ignored
        snoop(A0, 5'b10101, 1, 1, "R4");             // reserved 1xx01
        snoop(A0, 5'b00101, 0, 0, "R4");             // reserved
        fill(A0, 2'b10);
        snoop(A0, 5'b01010, 0, 1, "R7");             // M -> retry, push, E
        step("R2");                                  // pulse lasts one cycle
        fill(A0, 2'b10);
        snoop(A0, 5'b01010, 0, 0, "R8");             // single-beat cacheable read: drop
        fill(A0, 2'b10);
        snoop(A0, 5'b00110, 1, 0, "R6");             // kill M: no push
        fill(A0, 2'b10);
        snoop(A0, 5'b00010, 0, 1, "R5");             // flush M: push, I
        // reservation cleared on a miss
        idle(); rsv_set = 1; rsv_addr = A1 | 32'h4; step("R11"); idle();
        snoop(A1 | 32'h1C, 5'b00010, 0, 0, "R9");
        // same-cycle set and cancel on one block
        idle(); rsv_set = 1; rsv_addr = A0; snp_valid = 1; snp_addr = A0 | 32'h8;
        snp_type = 5'b00110; snp_burst = 1; snp_inhibit = 0; step("R11"); idle();
        // reservation survives a read of its block
        idle(); rsv_set = 1; rsv_addr = A0; step("R11"); idle();
        snoop(A0, 5'b01010, 1, 0, "R9");

        void'($urandom(32'd7531));
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a;
            a = {pool[$urandom % 4], 4'($urandom), 5'($urandom)};
            snp_valid   = ($urandom % 10) < 8;
            snp_addr    = a;
            snp_type    = ($urandom % 2) ? ((($urandom % 3) == 0) ? 5'b00010 :
                          (($urandom % 2) ? 5'b00110 : 5'b01010)) : 5'($urandom);
            snp_burst   = 1'($urandom);
            snp_inhibit = 1'($urandom);
            fill_valid  = ($urandom % 10) < 4;
            fill_addr   = {pool[$urandom % 4], 4'($urandom), 5'($urandom)};
            fill_state  = 2'($urandom % 3);
            if (snp_valid && fill_addr[8:5] == a[8:5]) fill_valid = 0;
            rsv_set     = ($urandom % 10) < 2;
            rsv_addr    = ($urandom % 2) ? a : {pool[$urandom % 4], 4'($urandom), 5'($urandom)};
            step("");
        end
        idle();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule